// File: doc/BRIEF.md
# Toggle Bit Completion Poller

This block sits on the host side of a parallel flash device. After software or another engine has issued a program or erase command, it pulses `startPulse` with the address to poll. The controller then reads device status over a simple request/response bus and watches the status bit that flips on every read while an internal operation is running. When two reads in a row agree on that bit, the operation is over. When they disagree, the controller looks at the time-limit flag in the same status byte. If the flag is clear, it keeps polling in read pairs. If the flag is set, it does one more pair of reads, because the device may have stopped flipping at the same moment the flag rose.

The run ends with a one-cycle `done` pulse and a `pass` flag. On any failure, the controller first writes the device's reset command so that the device goes back to array-read mode. A limit on the number of read pairs turns a device that never settles into a failure. A request to abandon the run drops it back to idle without a `done` pulse. Any later start repeats the whole sequence from its first read.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: Out of reset, and until the first start, `reqValid`, `done` and `busy` are low.
- R2: A run begins with two reads of the address captured at start. Each read is held on the bus until `reqReady`, and no new request is issued until the response for the previous read has arrived on `rspValid`.
- R3: If bit 6 (the flip bit) of a pair's two reads is equal, the run ends as a pass after that pair, with no write.
- R4: If bit 6 differs and bit 5 (the time-limit flag) of the second read is 0, another read pair follows.
- R5: If bit 6 differs and bit 5 of the second read is 1, exactly two more reads follow. If their bit 6 values agree, the run is a pass.
- R6: If those two extra reads disagree on bit 6, the run fails. Before `done`, one bus write of `RST_DATA` to `RST_ADDR` is made (`reqWrite`=1). `done` follows in the cycle after that write is accepted, with `pass`=0.
- R7: If the pair count reaches `MAX_PAIRS` with bit 6 differing and bit 5 at 0 every time, the run fails with the same reset write. Such a run makes exactly 2*`MAX_PAIRS` reads.
- R8: An `abortReq` during a run is held until the next read response, which is discarded. The controller then goes idle with no `done` and no write. The next start begins again with a fresh two-read step.
- R9: `startPulse` while busy and `abortReq` while idle have no effect.
- R10: `done` is high for exactly one cycle per completed run. `pass` is valid in that cycle, and `busy` is low in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Launch a polling run (used only when idle) |
| abortReq | input | 1 | Abandon the current run |
| pollAddr | input | ADDR_W | Address read for status, captured at start |
| reqValid | output | 1 | Bus request valid |
| reqReady | input | 1 | Bus accepts the request this cycle |
| reqWrite | output | 1 | 1 = write request, 0 = read request |
| reqAddr | output | ADDR_W | Request address |
| reqWdata | output | DATA_W | Write data |
| rspValid | input | 1 | Read data returned this cycle |
| rspData | input | DATA_W | Read data |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Result, valid with done |
| busy | output | 1 | A run is in progress |

## Verification
The bench models a device whose flip bit stops after a chosen number of reads and whose time-limit flag rises at a chosen read. The ready and response delays are randomized. The race in which flipping stops just as the flag rises is aimed at directly. A controller that decided right after seeing the flag would report failure there instead of a pass. A controller that skipped the reset write, or wrote after `done`, would show a wrong write count at the pulse. Abandoned runs followed by a restart, and starts issued mid-run, expose designs that reuse a stored flip value or restart the sequence, because the read count comes out wrong. The stuck-device case checks that the pair limit ends the run after exactly 2*`MAX_PAIRS` reads.

// File: rtl/tpoll_pkg.sv
package tpoll_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RDA,
    S_WTA,
    S_RDB,
    S_WTB,
    S_RCA,
    S_RCWA,
    S_RCB,
    S_RCWB,
    S_WR,
    S_FIN
  } pollState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic captureAddr;
    logic clrRun;
    logic loadFirst;
    logic incPair;
    logic setPass;
    logic setFail;
    logic issueWr;
    logic armAbort;
  } pollStrb_t;

  // datapath -> control status
  typedef struct packed {
    logic togDiffer;
    logic toutSeen;
    logic pairLast;
    logic abortPend;
  } pollStat_t;

endpackage

// File: rtl/tpoll_dp.sv
module tpoll_dp
  import tpoll_pkg::*;
#(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned TOG_BIT   = 6,
  parameter int unsigned TOUT_BIT  = 5,
  parameter int unsigned MAX_PAIRS = 16,
  parameter logic [ADDR_W-1:0] RST_ADDR = ADDR_W'('h555),
  parameter logic [DATA_W-1:0] RST_DATA = DATA_W'('hF0)
) (
  input  logic              clk,
  input  logic              rstN,
  input  pollStrb_t         strb,
  input  logic              abortReq,
  input  logic [ADDR_W-1:0] pollAddr,
  input  logic [DATA_W-1:0] rspData,
  output pollStat_t         stat,
  output logic              reqWrite,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqWdata,
  output logic              pass
);

  localparam int unsigned CNT_W = $clog2(MAX_PAIRS + 1);
  localparam logic [CNT_W-1:0] LAST_PAIR = CNT_W'(MAX_PAIRS - 1);

  logic [ADDR_W-1:0] pollAddrQ;
  logic              firstTog;
  logic [CNT_W-1:0]  pairCnt;
  logic              passQ;
  logic              abortQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pollAddrQ <= '0;
      firstTog  <= 1'b0;
      pairCnt   <= '0;
      passQ     <= 1'b0;
      abortQ    <= 1'b0;
    end else begin
      if (strb.captureAddr) pollAddrQ <= pollAddr;
      if (strb.loadFirst)   firstTog  <= rspData[TOG_BIT];
      if (strb.clrRun)      pairCnt   <= '0;
      else if (strb.incPair) pairCnt  <= pairCnt + 1'b1;
      if (strb.clrRun)       passQ <= 1'b0;
      else if (strb.setPass) passQ <= 1'b1;
      else if (strb.setFail) passQ <= 1'b0;
      if (strb.clrRun)                        abortQ <= 1'b0;
      else if (strb.armAbort && abortReq)     abortQ <= 1'b1;
    end
  end

  always_comb begin
    stat.togDiffer = rspData[TOG_BIT] ^ firstTog;
    stat.toutSeen  = rspData[TOUT_BIT];
    stat.pairLast  = (pairCnt == LAST_PAIR);
    stat.abortPend = abortQ;
  end

  assign reqWrite = strb.issueWr;
  assign reqAddr  = strb.issueWr ? RST_ADDR : pollAddrQ;
  assign reqWdata = strb.issueWr ? RST_DATA : '0;
  assign pass     = passQ;

endmodule

// File: rtl/tpoll_ctrl.sv
module tpoll_ctrl
  import tpoll_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startPulse,
  input  logic      reqReady,
  input  logic      rspValid,
  input  pollStat_t stat,
  output pollStrb_t strb,
  output logic      reqValid,
  output logic      done,
  output logic      busy
);

  pollState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    reqValid  = 1'b0;
    strb.armAbort = (state != S_IDLE) && (state != S_WR) && (state != S_FIN);
    unique case (state)
      S_IDLE: begin
        if (startPulse) begin
          strb.captureAddr = 1'b1;
          strb.clrRun      = 1'b1;
          nextState        = S_RDA;
        end
      end
      S_RDA, S_RDB, S_RCA, S_RCB: begin
        reqValid = 1'b1;
        if (reqReady) begin
          unique case (state)
            S_RDA:   nextState = S_WTA;
            S_RDB:   nextState = S_WTB;
            S_RCA:   nextState = S_RCWA;
            default: nextState = S_RCWB;
          endcase
        end
      end
      S_WTA, S_RCWA: begin
        if (rspValid) begin
          if (stat.abortPend) begin
            nextState = S_IDLE;
          end else begin
            strb.loadFirst = 1'b1;
            nextState      = (state == S_WTA) ? S_RDB : S_RCB;
          end
        end
      end
      S_WTB: begin
        if (rspValid) begin
          if (stat.abortPend) begin
            nextState = S_IDLE;
          end else if (!stat.togDiffer) begin
            strb.setPass = 1'b1;
            nextState    = S_FIN;
          end else if (stat.toutSeen) begin
            nextState = S_RCA;
          end else if (stat.pairLast) begin
            strb.setFail = 1'b1;
            nextState    = S_WR;
          end else begin
            strb.incPair = 1'b1;
            nextState    = S_RDA;
          end
        end
      end
      S_RCWB: begin
        if (rspValid) begin
          if (stat.abortPend) begin
            nextState = S_IDLE;
          end else if (!stat.togDiffer) begin
            strb.setPass = 1'b1;
            nextState    = S_FIN;
          end else begin
            strb.setFail = 1'b1;
            nextState    = S_WR;
          end
        end
      end
      S_WR: begin
        reqValid     = 1'b1;
        strb.issueWr = 1'b1;
        if (reqReady) nextState = S_FIN;
      end
      S_FIN: begin
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign done = (state == S_FIN);
  assign busy = (state != S_IDLE);

endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl
  import tpoll_pkg::*;
#(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned TOG_BIT   = 6,
  parameter int unsigned TOUT_BIT  = 5,
  parameter int unsigned MAX_PAIRS = 16,
  parameter logic [ADDR_W-1:0] RST_ADDR = ADDR_W'('h555),
  parameter logic [DATA_W-1:0] RST_DATA = DATA_W'('hF0)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              abortReq,
  input  logic [ADDR_W-1:0] pollAddr,
  output logic              reqValid,
  input  logic              reqReady,
  output logic              reqWrite,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqWdata,
  input  logic              rspValid,
  input  logic [DATA_W-1:0] rspData,
  output logic              done,
  output logic              pass,
  output logic              busy
);

  pollStrb_t strb;
  pollStat_t stat;

  tpoll_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .reqReady  (reqReady),
    .rspValid  (rspValid),
    .stat      (stat),
    .strb      (strb),
    .reqValid  (reqValid),
    .done      (done),
    .busy      (busy)
  );

  tpoll_dp #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .TOG_BIT  (TOG_BIT),
    .TOUT_BIT (TOUT_BIT),
    .MAX_PAIRS(MAX_PAIRS),
    .RST_ADDR (RST_ADDR),
    .RST_DATA (RST_DATA)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .abortReq(abortReq),
    .pollAddr(pollAddr),
    .rspData (rspData),
    .stat    (stat),
    .reqWrite(reqWrite),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .pass    (pass)
  );

endmodule

// File: rtl/tpoll_checker.sv
module tpoll_checker #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] RST_ADDR = ADDR_W'('h555),
  parameter logic [DATA_W-1:0] RST_DATA = DATA_W'('hF0)
) (
  input logic              clk,
  input logic              rstN,
  input logic              startPulse,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [DATA_W-1:0] reqWdata,
  input logic              done,
  input logic              busy
);

  // R2: one read outstanding, request idle until its response
  p_one_outstanding_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqWrite) |=> !reqValid);

  // R2: a pending request holds its address and kind
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> (reqValid && $stable(reqAddr) && $stable(reqWrite)));

  // R6: reset write carries the configured command
  p_reset_cmd_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |-> (reqAddr == RST_ADDR && reqWdata == RST_DATA));

  // R6: an accepted reset write is followed directly by a failing done
  p_write_then_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite) |=> done);

  // R10: done is a single-cycle pulse and the block then idles
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R9: a run only starts from a start request
  p_start_only_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startPulse));

endmodule

bind toggle_poll_ctrl tpoll_checker #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .RST_ADDR(RST_ADDR),
  .RST_DATA(RST_DATA)
) i_tpoll_checker (
  .clk       (clk),
  .rstN      (rstN),
  .startPulse(startPulse),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .reqWrite  (reqWrite),
  .reqAddr   (reqAddr),
  .reqWdata  (reqWdata),
  .done      (done),
  .busy      (busy)
);

// File: tb/test_toggle_poll_ctrl.sv
module test_toggle_poll_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 20;
  localparam int DATA_W     = 8;
  localparam int MAX_PAIRS  = 16;
  localparam logic [ADDR_W-1:0] RST_ADDR = 20'h00555;
  localparam logic [DATA_W-1:0] RST_DATA = 8'hF0;
  localparam int NEVER = 100000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startPulse = 1'b0;
  logic              abortReq = 1'b0;
  logic [ADDR_W-1:0] pollAddr = '0;
  logic              reqValid;
  logic              reqReady = 1'b0;
  logic              reqWrite;
  logic [ADDR_W-1:0] reqAddr;
  logic [DATA_W-1:0] reqWdata;
  logic              rspValid = 1'b0;
  logic [DATA_W-1:0] rspData = '0;
  logic              done;
  logic              pass;
  logic              busy;

  int nChk = 0;
  int nFail = 0;
  int cycles = 0;

  // device model state
  int busyLen = 0;
  int toutAt = NEVER;
  int rdIdx = 0;
  int wrCount = 0;
  int doneCount = 0;
  int addrErr = 0;
  bit lastPass = 1'b0;
  logic [ADDR_W-1:0] lastWrAddr = '0;
  logic [DATA_W-1:0] lastWrData = '0;
  bit pend = 1'b0;
  int pendDly = 0;
  logic [DATA_W-1:0] pendData = '0;

  toggle_poll_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_PAIRS(MAX_PAIRS),
    .RST_ADDR(RST_ADDR), .RST_DATA(RST_DATA)
  ) i_toggle_poll_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .abortReq(abortReq),
    .pollAddr(pollAddr), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .done(done), .pass(pass), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit togAt(int k);
    return (k < busyLen) ? k[0] : busyLen[0];
  endfunction

  function automatic logic [DATA_W-1:0] modelData(int k);
    logic [DATA_W-1:0] d;
    d = DATA_W'(k * 13 + 7);
    d[6] = togAt(k);
    d[5] = (k >= toutAt);
    return d;
  endfunction

  // expected outcome: pass flag, read count, requirement path
  function automatic void predict(output bit expPass, output int expReads, output string tag);
    int k = 0;
    int pairs = 0;
    expPass = 1'b0;
    tag = "R3";
    forever begin
      bit a, b, t;
      a = togAt(k); b = togAt(k + 1); t = (k + 1 >= toutAt);
      k += 2;
      if (a == b) begin expPass = 1'b1; break; end
      if (t) begin
        expPass = (togAt(k) == togAt(k + 1));
        k += 2;
        tag = expPass ? "R5" : "R6";
        break;
      end
      pairs++;
      tag = "R4";
      if (pairs == MAX_PAIRS) begin expPass = 1'b0; tag = "R7"; break; end
    end
    expReads = k;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // device / bus responder, acts at falling edges
  initial begin
    forever begin
      @(negedge clk);
      cycles++;
      if (!rstN) begin
        reqReady = 1'b0; rspValid = 1'b0; pend = 1'b0;
      end else begin
        rspValid = 1'b0;
        if (pend) begin
          if (pendDly == 0) begin
            rspValid = 1'b1; rspData = pendData; pend = 1'b0;
          end else pendDly--;
        end
        if (done) begin doneCount++; lastPass = pass; end
        reqReady = ($urandom_range(0, 3) != 0);
        if (reqValid && reqReady) begin
          if (reqWrite) begin
            wrCount++; lastWrAddr = reqAddr; lastWrData = reqWdata;
          end else begin
            if (reqAddr != pollAddr) addrErr++;
            pendData = modelData(rdIdx);
            rdIdx++;
            pend = 1'b1;
            pendDly = $urandom_range(0, 2);
          end
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      if (cycles > 150000) begin
        nFail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
        $finish;
      end
    end
  end

  task automatic runScen(int bl, int ta, bit midStart);
    bit expPass; int expReads; string tag;
    int d0; int n; bit sent;
    busyLen = bl; toutAt = ta;
    predict(expPass, expReads, tag);
    @(negedge clk);
    rdIdx = 0; wrCount = 0; addrErr = 0;
    pollAddr = ADDR_W'($urandom);
    d0 = doneCount;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    n = 0; sent = 1'b0;
    while (doneCount == d0 && n < 3000) begin
      @(negedge clk);
      n++;
      startPulse = 1'b0;
      if (midStart && !sent && rdIdx == 3) begin startPulse = 1'b1; sent = 1'b1; end
    end
    startPulse = 1'b0;
    check(doneCount == d0 + 1, "R10 done seen", doneCount - d0, 1);
    check(lastPass == expPass, {tag, " pass"}, lastPass, expPass);
    check(rdIdx == expReads, midStart ? "R9 reads" : {tag, " reads"}, rdIdx, expReads);
    check(addrErr == 0, "R2 read addr", addrErr, 0);
    check(wrCount == (expPass ? 0 : 1), expPass ? "R3 no write" : "R6 reset write",
          wrCount, expPass ? 0 : 1);
    if (!expPass)
      check(lastWrAddr == RST_ADDR && lastWrData == RST_DATA, "R6 write cmd",
            int'(lastWrData), int'(RST_DATA));
    @(negedge clk);
    check(!done && !busy, "R10 single pulse", int'(done), 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(!reqValid && !done && !busy, "R1 in reset", int'(reqValid), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!reqValid && !done && !busy, "R1 after reset", int'(busy), 0);

    runScen(0, NEVER, 1'b0);          // R3 settled at once
    runScen(7, NEVER, 1'b0);          // R4 more pairs then pass
    runScen(2, 1, 1'b0);              // R5 race: stops during re-check
    runScen(1000, 3, 1'b0);           // R6 re-check still flipping
    runScen(1000, NEVER, 1'b0);       // R7 pair limit
    runScen(9, NEVER, 1'b1);          // R9 start while busy

    // R9: abort while idle is ignored
    @(negedge clk); abortReq = 1'b1;
    @(negedge clk); abortReq = 1'b0;
    check(!busy && !reqValid, "R9 idle abort", int'(busy), 0);
    runScen(0, NEVER, 1'b0);

    // R8: abandon mid-run, then restart from a fresh pair
    begin
      int d0; int n;
      busyLen = 1000; toutAt = NEVER;
      @(negedge clk);
      rdIdx = 0; wrCount = 0; d0 = doneCount;
      startPulse = 1'b1;
      @(negedge clk); startPulse = 1'b0;
      n = 0;
      while (rdIdx < 3 && n < 200) begin @(negedge clk); n++; end
      abortReq = 1'b1;
      @(negedge clk); abortReq = 1'b0;
      n = 0;
      while (busy && n < 100) begin @(negedge clk); n++; end
      repeat (4) @(negedge clk);
      check(!busy, "R8 idle after abort", int'(busy), 0);
      check(doneCount == d0, "R8 no done", doneCount - d0, 0);
      check(wrCount == 0, "R8 no write", wrCount, 0);
    end
    runScen(0, NEVER, 1'b0);          // R8 restart begins anew

    for (int i = 0; i < 20; i++) begin
      int bl; int ta;
      bl = $urandom_range(0, 40);
      ta = ($urandom_range(0, 2) == 0) ? NEVER : $urandom_range(0, 50);
      runScen(bl, ta, 1'b0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule